// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Byte Queues

This block is a serial port peripheral sitting on a plain 32-bit register bus. Software writes bytes to a transmit data register; each accepted byte joins a small transmit queue, and a serializer drains that queue onto the transmit line as 8N1 frames: one low start bit, eight data bits least significant first, and one high stop bit. A deserializer watches the receive line, samples each bit near its middle, and places good bytes in a receive queue. Software drains that queue by reading a receive data register.

Queue status is folded into bit 31 of the two data registers, so one read tells software both the state and, on the receive side, the data. A separate control word enables each direction. A divisor register sets the bit period to the divisor plus one system clock cycles, so the reset value of 138 gives roughly 115200 baud from a 16 MHz clock.

Top module: `uart_mmio`

## Requirements
- R1: A write to offset 0x0 puts bits 7:0 into the transmit queue (8 entries) when it is not full; a write while it holds 8 entries is dropped and that byte is never sent.
- R2: A read of offset 0x0 returns the transmit-full flag in bit 31 and zero in bits 30:0.
- R3: A read of offset 0x4 returns the receive-empty flag in bit 31, zero in bits 30:8 and the oldest byte in bits 7:0, and removes that byte; when empty the whole word reads 0x80000000 and the queue is left unchanged.
- R4: A write to offset 0x4 has no effect on the receive queue.
- R5: Bit 0 at offset 0x8 enables the transmitter and bit 0 at offset 0xC enables the receiver; both reset to 0 and read back. Offset 0x18 holds the bit-period divisor, reset value 138, and reads back.
- R6: The transmit line idles high; each frame is a 0 start bit, data bits 0 to 7 in order, then a 1 stop bit, each bit lasting divisor plus one clock cycles.
- R7: While the transmitter is disabled no new frame starts, the line stays high and queued bytes are kept until it is enabled again.
- R8: The receiver detects a falling edge of the line, checks it is still low half a bit period later, and otherwise treats it as a false start and receives nothing.
- R9: A received frame whose stop bit samples low is dropped.
- R10: A byte that completes while the receive queue holds 8 entries is discarded; the 8 earlier bytes stay intact.
- R11: While the receiver is disabled, frames on the line are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| uart_rxd | input | 1 | Serial receive line |
| uart_txd | output | 1 | Serial transmit line |

## Verification
The bench fills the transmit queue while the transmitter is off and then writes one extra byte. A design that accepted the extra write would emit a ninth frame, and one that leaked the write data into the readback would show nonzero low bits. It reads the empty receive register twice around a real frame: a design that moved its pointers on an empty read would hand back stale or skipped data. A short low glitch, a frame with a low stop bit, a ninth byte into a full queue and a frame sent while the receiver is off must all leave no byte behind. A sampler placed off mid-bit, or with the wrong bit order, corrupts every checked byte.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
   localparam int unsigned OFS_TXDATA = 'h00;
   localparam int unsigned OFS_RXDATA = 'h04;
   localparam int unsigned OFS_TXCTRL = 'h08;
   localparam int unsigned OFS_RXCTRL = 'h0C;
   localparam int unsigned OFS_DIVISOR = 'h18;
   localparam int unsigned FLAG_BIT = 31;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
   parameter int unsigned DW = 8,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop) rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [DIV_W-1:0] divisor,
   input  logic             q_empty,
   input  logic [7:0]       q_data,
   output logic             q_pop,
   output logic             txd,
   output logic             busy
);
   logic [9:0]       shreg;
   logic [3:0]       bit_idx;
   logic [DIV_W-1:0] tick;

   assign q_pop = enable && !busy && !q_empty;
   assign txd   = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         shreg   <= '1;
         bit_idx <= '0;
         tick    <= '0;
      end else if (q_pop) begin
         busy    <= 1'b1;
         shreg   <= {1'b1, q_data, 1'b0};
         bit_idx <= '0;
         tick    <= '0;
      end else if (busy) begin
         if (tick == divisor) begin
            tick  <= '0;
            shreg <= {1'b1, shreg[9:1]};
            if (bit_idx == 4'd9) busy <= 1'b0;
            else bit_idx <= bit_idx + 1'b1;
         end else begin
            tick <= tick + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
   import uart_mmio_pkg::*;
#(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [DIV_W-1:0] divisor,
   input  logic             rxd,
   output logic             push,
   output logic [7:0]       data
);
   rx_state_e        state;
   logic             prev;
   logic [2:0]       bit_idx;
   logic [DIV_W-1:0] tick;
   logic             at_end;

   assign at_end = (tick == divisor);
   assign push   = enable && (state == RX_STOP) && at_end && rxd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         prev    <= 1'b1;
         bit_idx <= '0;
         tick    <= '0;
         data    <= '0;
      end else begin
         prev <= rxd;
         if (!enable) begin
            state <= RX_IDLE;
         end else begin
            case (state)
               RX_IDLE: begin
                  tick <= '0;
                  if (prev && !rxd) state <= RX_START;
               end
               RX_START: begin
                  if (tick == (divisor >> 1)) begin
                     tick    <= '0;
                     bit_idx <= '0;
                     state   <= rxd ? RX_IDLE : RX_DATA;
                  end else tick <= tick + 1'b1;
               end
               RX_DATA: begin
                  if (at_end) begin
                     tick <= '0;
                     data <= {rxd, data[7:1]};
                     if (bit_idx == 3'd7) state <= RX_STOP;
                     else bit_idx <= bit_idx + 1'b1;
                  end else tick <= tick + 1'b1;
               end
               default: begin
                  if (at_end) state <= RX_IDLE;
                  else tick <= tick + 1'b1;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
   import uart_mmio_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned DIV_W = 16,
   parameter int unsigned DIV_RESET = 138,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              uart_rxd,
   output logic              uart_txd
);
   if (ADDR_W < 5) begin : g_chk_addr
      $error("ADDR_W must cover offset 0x18");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DIV_W < 8 || DIV_W > 31 || DIV_RESET >= (1 << DIV_W)) begin : g_chk_div
      $error("DIV_W out of range or DIV_RESET does not fit");
   end
   if (SYNC_STAGES < 1) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic             tx_en, rx_en;
   logic [DIV_W-1:0] div_q;
   logic             wr, rd;
   logic             sel_tx, sel_rx, sel_txc, sel_rxc, sel_div;
   logic             tx_wr, rx_rd;
   logic             tx_pop, tx_full, tx_empty, tx_busy;
   logic [7:0]       tx_head;
   logic [CW-1:0]    tx_cnt;
   logic             rx_push, rx_full, rx_empty;
   logic [7:0]       rx_byte, rx_head;
   logic [CW-1:0]    rx_cnt;
   logic             rxd_sync;
   logic [31:DIV_W]  unused_wbits;

   assign unused_wbits = bus_wdata[31:DIV_W];
   assign wr      = bus_sel && bus_we;
   assign rd      = bus_sel && !bus_we;
   assign sel_tx  = (bus_addr == ADDR_W'(OFS_TXDATA));
   assign sel_rx  = (bus_addr == ADDR_W'(OFS_RXDATA));
   assign sel_txc = (bus_addr == ADDR_W'(OFS_TXCTRL));
   assign sel_rxc = (bus_addr == ADDR_W'(OFS_RXCTRL));
   assign sel_div = (bus_addr == ADDR_W'(OFS_DIVISOR));
   assign tx_wr   = wr && sel_tx;
   assign rx_rd   = rd && sel_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en <= 1'b0;
         rx_en <= 1'b0;
         div_q <= DIV_W'(DIV_RESET);
      end else if (wr) begin
         if (sel_txc) tx_en <= bus_wdata[0];
         if (sel_rxc) rx_en <= bus_wdata[0];
         if (sel_div) div_q <= bus_wdata[DIV_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_tx) bus_rdata[FLAG_BIT] = tx_full;
      if (sel_rx) begin
         bus_rdata[FLAG_BIT] = rx_empty;
         bus_rdata[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
      end
      if (sel_txc) bus_rdata[0] = tx_en;
      if (sel_rxc) bus_rdata[0] = rx_en;
      if (sel_div) bus_rdata[DIV_W-1:0] = div_q;
   end

   // Receive line synchronizer, depth picked by SYNC_STAGES
   logic [SYNC_STAGES-1:0] sync_q;
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b1;
         else if (s == 0) sync_q[s] <= uart_rxd;
         else sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
      end
   end
   assign rxd_sync = sync_q[SYNC_STAGES-1];

   uart_fifo #(.DW(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(bus_wdata[7:0]),
      .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty),
      .count(tx_cnt)
   );

   uart_tx_engine #(.DIV_W(DIV_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .enable(tx_en), .divisor(div_q),
      .q_empty(tx_empty), .q_data(tx_head), .q_pop(tx_pop),
      .txd(uart_txd), .busy(tx_busy)
   );

   uart_fifo #(.DW(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
      .pop(rx_rd), .dout(rx_head), .full(rx_full), .empty(rx_empty),
      .count(rx_cnt)
   );

   uart_rx_engine #(.DIV_W(DIV_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .enable(rx_en), .divisor(div_q),
      .rxd(rxd_sync), .push(rx_push), .data(rx_byte)
   );
endmodule

// File: rtl/uart_mmio_chk.sv
module uart_mmio_chk #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          txd,
   input logic          tx_en,
   input logic          tx_busy,
   input logic          tx_pop,
   input logic          tx_wr,
   input logic [CW-1:0] tx_cnt,
   input logic          rx_en,
   input logic          rx_push,
   input logic          rx_rd,
   input logic [CW-1:0] rx_cnt
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH)); // R1
   AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == CW'(DEPTH) && tx_wr && !tx_pop) |=> tx_cnt == CW'(DEPTH)); // R1
   AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd); // R6
   AST_TX_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !tx_busy) |=> (tx_cnt >= $past(tx_cnt) && !tx_busy)); // R7
   AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == '0 && rx_rd && !rx_push) |=> rx_cnt == '0); // R3
   AST_RX_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == CW'(DEPTH) && !rx_rd) |=> rx_cnt == CW'(DEPTH)); // R10
   AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !rx_rd) |=> $stable(rx_cnt)); // R11
endmodule

bind uart_mmio uart_mmio_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .txd(uart_txd), .tx_en(tx_en),
   .tx_busy(tx_busy), .tx_pop(tx_pop), .tx_wr(tx_wr), .tx_cnt(tx_cnt),
   .rx_en(rx_en), .rx_push(rx_push), .rx_rd(rx_rd), .rx_cnt(rx_cnt)
);

// File: tb/uart_mmio_test.sv
module uart_mmio_test;
   localparam int BIT = 8;   // divisor 7 -> 8 cycles per bit

   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_sel = 0, bus_we = 0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        uart_rxd = 1;
   logic        uart_txd;

   int n_checks = 0;
   int n_fail = 0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   uart_mmio uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .uart_rxd(uart_rxd), .uart_txd(uart_txd)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string req);
      logic [31:0] d;
      bus_read(a, d);
      check(d === e, req, d, e);
   endtask

   // driver: queue the byte as expected output, then write it
   task automatic send_tx(input logic [7:0] b, input bit expect_out);
      if (expect_out) exp_q.push_back(b);
      bus_write(8'h00, {24'h0, b});
   endtask

   task automatic drive_frame(input logic [7:0] b, input logic stop);
      @(negedge clk);
      uart_rxd = 0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         uart_rxd = b[i];
         repeat (BIT) @(negedge clk);
      end
      uart_rxd = stop;
      repeat (BIT) @(negedge clk);
      uart_rxd = 1;
      repeat (2 * BIT) @(negedge clk);
   endtask

   // monitor: decode frames on the transmit line, compare with the queue (R6)
   initial begin
      forever begin
         logic [7:0] got;
         logic [7:0] want;
         @(negedge uart_txd);
         repeat (BIT / 2) @(negedge clk);
         check(uart_txd === 1'b0, "R6 start bit", {31'h0, uart_txd}, 32'h0);
         for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            got[i] = uart_txd;
         end
         repeat (BIT) @(negedge clk);
         check(uart_txd === 1'b1, "R6 stop bit", {31'h0, uart_txd}, 32'h1);
         if (exp_q.size() == 0) begin
            check(1'b0, "R1 unexpected frame", {24'h0, got}, 32'h0);
         end else begin
            want = exp_q.pop_front();
            check(got === want, "R6 frame data", {24'h0, got}, {24'h0, want});
         end
      end
   end

   task automatic run_tests();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // reset state (R5, R2, R3, R6)
      check(uart_txd === 1'b1, "R6 idle high at reset", {31'h0, uart_txd}, 32'h1);
      expect_reg(8'h08, 32'h0, "R5 tx enable reset");
      expect_reg(8'h0C, 32'h0, "R5 rx enable reset");
      expect_reg(8'h18, 32'd138, "R5 divisor reset");
      expect_reg(8'h00, 32'h0, "R2 tx read not full");
      expect_reg(8'h04, 32'h8000_0000, "R3 rx empty at reset");

      bus_write(8'h18, 32'd7);
      expect_reg(8'h18, 32'd7, "R5 divisor readback");
      bus_write(8'h08, 32'h1);
      expect_reg(8'h08, 32'h1, "R5 tx enable readback");

      // basic transmission (R1, R6)
      send_tx(8'h55, 1);
      send_tx(8'hA3, 1);
      send_tx(8'h01, 1);
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4 * BIT) @(negedge clk);

      // disabled transmitter keeps queue, full drop (R7, R1, R2)
      bus_write(8'h08, 32'h0);
      for (int i = 0; i < 8; i++) send_tx(8'hC0 + 8'(i), 1);
      send_tx(8'hEE, 0);
      expect_reg(8'h00, 32'h8000_0000, "R2 full flag with zero data");
      begin
         bit stayed_high = 1;
         for (int i = 0; i < 20 * BIT; i++) begin
            @(negedge clk);
            if (uart_txd !== 1'b1) stayed_high = 0;
         end
         check(stayed_high, "R7 line high while disabled", {31'h0, stayed_high}, 32'h1);
      end
      check(exp_q.size() == 8, "R7 nothing sent while disabled", exp_q.size(), 32'd8);
      bus_write(8'h08, 32'h1);
      while (exp_q.size() != 0) @(negedge clk);
      repeat (15 * BIT) @(negedge clk);
      expect_reg(8'h00, 32'h0, "R2 not full after drain");

      // receive path (R3)
      bus_write(8'h0C, 32'h1);
      drive_frame(8'hA5, 1);
      expect_reg(8'h04, 32'h0000_00A5, "R3 rx data");
      expect_reg(8'h04, 32'h8000_0000, "R3 empty after dequeue");
      expect_reg(8'h04, 32'h8000_0000, "R3 empty read again");
      drive_frame(8'h3C, 1);
      expect_reg(8'h04, 32'h0000_003C, "R3 pointers kept by empty reads");

      // write to rx data ignored (R4)
      bus_write(8'h04, 32'h0000_0077);
      expect_reg(8'h04, 32'h8000_0000, "R4 rx write ignored");

      // false start (R8)
      @(negedge clk);
      uart_rxd = 0;
      repeat (2) @(negedge clk);
      uart_rxd = 1;
      repeat (12 * BIT) @(negedge clk);
      expect_reg(8'h04, 32'h8000_0000, "R8 false start rejected");
      drive_frame(8'h81, 1);
      expect_reg(8'h04, 32'h0000_0081, "R8 good frame after glitch");

      // bad stop bit (R9)
      drive_frame(8'h42, 0);
      repeat (4 * BIT) @(negedge clk);
      expect_reg(8'h04, 32'h8000_0000, "R9 bad stop dropped");
      drive_frame(8'h99, 1);
      expect_reg(8'h04, 32'h0000_0099, "R9 recovery frame");

      // receive queue overflow (R10)
      for (int i = 0; i < 9; i++) drive_frame(8'h10 + 8'(i), 1);
      for (int i = 0; i < 8; i++)
         expect_reg(8'h04, {24'h0, 8'h10 + 8'(i)}, "R10 kept entries");
      expect_reg(8'h04, 32'h8000_0000, "R10 ninth byte discarded");

      // receiver disabled (R11)
      bus_write(8'h0C, 32'h0);
      expect_reg(8'h0C, 32'h0, "R5 rx enable cleared");
      drive_frame(8'h5A, 1);
      bus_write(8'h0C, 32'h1);
      expect_reg(8'h04, 32'h8000_0000, "R11 frame ignored while off");
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            check(1'b0, "watchdog expired", 32'h0, 32'h1);
         end
      join_any
      disable fork;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule